// File: doc/BRIEF.md
# Sigma-Delta Converter Serial Readout Controller

This block is a serial-bus master for one 24-bit sigma-delta converter. The converter uses a single output pin for two jobs. Between transfers the pin signals that a result is ready. During a transfer it carries the result bits. After reset the controller writes a fixed list of setup words to the converter in one chip-select-low frame. The words set the channel enables, the filter and data rate, and a final mode word that leaves the converter converting continuously. The list is a parameter of the block.

After setup the controller waits. A falling edge on the shared line while it is idle means a conversion has finished. The controller then opens a read frame at once and shifts in the 24 result bits. It presents the word for one cycle, tagged with a channel index. The index follows the converter's 16-step scan and wraps from 15 back to 0.

The serial clock is the system clock divided down. The serial clock idles high. Data is launched on its falling edge and sampled on its rising edge. Chip select stays high for a minimum number of cycles between frames, and the ready line is ignored during that time.

Top module: `sdadc_spi_ctrl`

## Requirements
- R1: While reset is held, `cs_n`, `sclk` and `mosi` are high, `res_valid` is low, and `res_data` and `res_chan` are zero.
- R2: Setup after reset works as follows.
  - The first frame after reset is the setup frame, and chip select stays low for all of it.
  - It shifts all `CFG_WORDS*CFG_W` bits of `CFG_TABLE` on `mosi`, starting at the most significant bit. Word 0 sits in the top bits.
  - Chip select first falls `CS_GAP-1` cycles after reset is released.
- R3: Every frame follows the same timing.
  - It opens with one lead half-period in which `sclk` is high while chip select is low.
  - Each bit then takes a low half-period followed by a high half-period. A half-period is `HALF_DIV` clock cycles.
  - `mosi` changes only where `sclk` falls or where chip select rises.
  - Chip select rises when the last high half-period ends.
- R4: Read frames start only after the setup frame. Each read frame takes exactly `RES_W` bits, most significant bit first, sampled as `sclk` rises. `mosi` stays high throughout.
- R5: Suppose the ready line is driven low between two clock edges while the controller is idle. Chip select then falls at the third rising clock edge after that change.
- R6: Only a high-to-low change seen while idle starts a read. The line is ignored during any frame and during the chip-select-high gap. A line that is already low when the controller becomes idle starts nothing.
- R7: Between two frames, chip select stays high for at least `CS_GAP` clock cycles.
- R8: `res_valid` pulses for exactly one cycle, the cycle right after chip select rises at the end of a read frame. In that cycle `res_data` holds the received word.
- R9: The first result carries channel index 0. Each later result carries the previous index plus one, wrapping from `NCH-1` to 0. Outside the valid cycle, `res_data` and `res_chan` hold their values.
- R10: `sclk` is high whenever chip select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rdy_dout | input | 1 | Converter's shared result-data and ready line |
| cs_n | output | 1 | Chip select, active low |
| sclk | output | 1 | Serial clock; idles high |
| mosi | output | 1 | Serial data to the converter |
| res_valid | output | 1 | One-cycle strobe for a new result |
| res_data | output | RES_W | Received conversion result |
| res_chan | output | $clog2(NCH) | Channel index attached to the result |

## Verification
The tightest collision is between the ready edge and the end of the chip-select-high gap. The edge detector and the gap counter can finish on the same clock edge, and whether a read starts depends on which state the controller is in at that moment. The bench provokes this by placing a ready falling edge so that its detection lands one edge before the controller turns idle, where it must be lost. It then places another edge one edge later, where it must start a frame. A cycle-accurate model compares chip select, the serial clock, `mosi` and the result outputs on every cycle. A missed, early or extra frame therefore shows up in the very cycle it goes wrong.

// File: rtl/sdadc_spi_ctrl.sv
module sdadc_spi_ctrl #(
  parameter int HALF_DIV  = 4,
  parameter int CS_GAP    = 6,
  parameter int RES_W     = 24,
  parameter int NCH       = 16,
  parameter int CFG_WORDS = 4,
  parameter int CFG_W     = 24,
  // channel enables, filter setup, data rate, continuous-conversion mode
  parameter logic [CFG_WORDS*CFG_W-1:0] CFG_TABLE = 96'h01_8001_20_1320_28_050A_0C_2000
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     rdy_dout,
  output logic                     cs_n,
  output logic                     sclk,
  output logic                     mosi,
  output logic                     res_valid,
  output logic [RES_W-1:0]         res_data,
  output logic [$clog2(NCH)-1:0]   res_chan
);
  localparam int CFG_BITS = CFG_WORDS * CFG_W;
  localparam int CH_W     = $clog2(NCH);
  localparam int HP_W     = $clog2(2 * CFG_BITS + 2);
  localparam int DIV_W    = $clog2(HALF_DIV);
  localparam int GAP_W    = $clog2(CS_GAP + 1);

  typedef enum logic [1:0] {S_GAP, S_IDLE, S_XFER} state_t;

  state_t              st;
  logic [GAP_W-1:0]    gap;
  logic [DIV_W-1:0]    div;
  logic [HP_W-1:0]     hp;
  logic                rd, cfg_done;
  logic [CFG_BITS-1:0] sh;
  logic [RES_W-1:0]    rx;
  logic [CH_W-1:0]     ch_next;
  logic                s1, s2, s3;
  logic                rdy_fall;
  logic [HP_W-1:0]     hp_last;

  assign rdy_fall = s3 & ~s2;
  assign hp_last  = rd ? HP_W'(2 * RES_W) : HP_W'(2 * CFG_BITS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b1;
      s2 <= 1'b1;
      s3 <= 1'b1;
    end else begin
      s1 <= rdy_dout;
      s2 <= s1;
      s3 <= s2;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_GAP;
      gap       <= '0;
      div       <= '0;
      hp        <= '0;
      rd        <= 1'b0;
      cfg_done  <= 1'b0;
      sh        <= '0;
      rx        <= '0;
      ch_next   <= '0;
      cs_n      <= 1'b1;
      sclk      <= 1'b1;
      mosi      <= 1'b1;
      res_valid <= 1'b0;
      res_data  <= '0;
      res_chan  <= '0;
    end else begin
      res_valid <= 1'b0;
      case (st)
        S_GAP: begin
          if (gap == GAP_W'(CS_GAP - 1)) begin
            gap <= '0;
            if (!cfg_done) begin
              st   <= S_XFER;
              cs_n <= 1'b0;
              rd   <= 1'b0;
              sh   <= CFG_TABLE;
            end else begin
              st <= S_IDLE;
            end
          end else begin
            gap <= gap + 1'b1;
          end
        end
        S_IDLE: begin
          if (rdy_fall) begin
            st   <= S_XFER;
            cs_n <= 1'b0;
            rd   <= 1'b1;
          end
        end
        default: begin
          if (div == DIV_W'(HALF_DIV - 1)) begin
            div <= '0;
            if (hp == hp_last) begin
              hp   <= '0;
              st   <= S_GAP;
              cs_n <= 1'b1;
              sclk <= 1'b1;
              mosi <= 1'b1;
              if (rd) begin
                res_valid <= 1'b1;
                res_data  <= rx;
                res_chan  <= ch_next;
                ch_next   <= (ch_next == CH_W'(NCH - 1)) ? '0 : ch_next + 1'b1;
              end else begin
                cfg_done <= 1'b1;
              end
            end else begin
              hp <= hp + 1'b1;
              if (sclk) begin
                sclk <= 1'b0;
                mosi <= rd ? 1'b1 : sh[CFG_BITS-1];
                sh   <= {sh[CFG_BITS-2:0], 1'b0};
              end else begin
                sclk <= 1'b1;
                rx   <= {rx[RES_W-2:0], s2};
              end
            end
          end else begin
            div <= div + 1'b1;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/sdadc_spi_ctrl_chk.sv
module sdadc_spi_ctrl_chk #(
  parameter int CS_GAP = 6,
  parameter int NCH    = 16,
  parameter int CH_W   = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cs_n,
  input logic            sclk,
  input logic            mosi,
  input logic            res_valid,
  input logic [CH_W-1:0] res_chan
);
  int              hi_run;
  logic [CH_W-1:0] last_chan;
  logic            seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_run    <= 0;
      last_chan <= '0;
      seen      <= 1'b0;
    end else begin
      hi_run <= cs_n ? ((hi_run < 65535) ? hi_run + 1 : hi_run) : 0;
      if (res_valid) begin
        last_chan <= res_chan;
        seen      <= 1'b1;
      end
    end
  end

  // R10
  sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) cs_n |-> sclk);
  // R3
  sclk_fall_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n) $fell(sclk) |-> !cs_n);
  // R3
  mosi_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mosi) |-> ($fell(sclk) || $rose(cs_n)));
  // R7
  cs_gap_chk: assert property (@(posedge clk) disable iff (!rst_n) $fell(cs_n) |-> hi_run >= CS_GAP);
  // R8
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) res_valid |=> !res_valid);
  // R8
  valid_after_frame_chk: assert property (@(posedge clk) disable iff (!rst_n) res_valid |-> $rose(cs_n));
  // R9
  chan_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !seen) |-> res_chan == '0);
  // R9
  chan_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && seen) |-> res_chan == ((last_chan == CH_W'(NCH - 1)) ? '0 : last_chan + 1'b1));
  // R9
  chan_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) !res_valid |-> $stable(res_chan));
endmodule

bind sdadc_spi_ctrl sdadc_spi_ctrl_chk #(.CS_GAP(CS_GAP), .NCH(NCH), .CH_W($clog2(NCH))) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .mosi(mosi),
  .res_valid(res_valid), .res_chan(res_chan)
);

// File: tb/test_sdadc_spi_ctrl.sv
module test_sdadc_spi_ctrl;
  localparam int HALF = 4;
  localparam int GAP  = 6;
  localparam int NW   = 4;
  localparam int CFGB = NW * 24;
  localparam logic [CFGB-1:0] TABLE = 96'hC3_5A0F_81_7E24_3C_99A5_0F_F001;

  logic        clk, rst_n, rdy;
  logic        cs_n, sclk, mosi, res_valid;
  logic [23:0] res_data;
  logic [3:0]  res_chan;

  sdadc_spi_ctrl #(.HALF_DIV(HALF), .CS_GAP(GAP), .RES_W(24), .NCH(16),
                   .CFG_WORDS(NW), .CFG_W(24), .CFG_TABLE(TABLE)) i_sdadc_spi_ctrl (
    .clk(clk), .rst_n(rst_n), .rdy_dout(rdy), .cs_n(cs_n), .sclk(sclk), .mosi(mosi),
    .res_valid(res_valid), .res_data(res_data), .res_chan(res_chan));

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int    checks = 0, errors = 0;
  bit    done = 0;
  string tag = "R1";
  logic  exp_cs = 1, exp_sclk = 1, exp_mosi = 1, exp_valid = 0;
  logic [23:0] exp_data = '0;
  logic [3:0]  exp_chan = '0;
  int    chan_cnt = 0;

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s at %0t: actual %h expected %h", req, what, $time, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    chk({31'd0, cs_n}, {31'd0, exp_cs}, tag, "cs_n");
    chk({31'd0, sclk}, {31'd0, exp_sclk}, exp_cs ? "R10" : "R3", "sclk");
    chk({31'd0, mosi}, {31'd0, exp_mosi}, tag, "mosi");
    chk({31'd0, res_valid}, {31'd0, exp_valid}, "R8", "res_valid");
    chk({8'd0, res_data}, {8'd0, exp_data}, exp_valid ? "R4" : "R9", "res_data");
    chk({28'd0, res_chan}, {28'd0, exp_chan}, "R9", "res_chan");
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) begin
      exp_cs = 1; exp_sclk = 1; exp_mosi = 1; exp_valid = 0;
      tick();
    end
  endtask

  task automatic run_xfer(input logic [CFGB-1:0] tx, input int n, input bit rd, input logic [23:0] v);
    tag = rd ? "R4" : "R2";
    for (int h = 0; h <= 2 * n; h++) begin
      for (int k = 0; k < HALF; k++) begin
        exp_cs = 0; exp_sclk = (h % 2 == 0); exp_valid = 0;
        exp_mosi = (rd || h == 0) ? 1'b1 : tx[CFGB - 1 - (h - 1) / 2];
        tick();
        if (k == 0) begin
          if (rd && (h % 2 == 1)) rdy = v[23 - (h - 1) / 2];
          else if (!rd) rdy = ((h % 4) < 2);
        end
      end
    end
    rdy = 1'b1;
    tag = "R7";
    exp_cs = 1; exp_sclk = 1; exp_mosi = 1; exp_valid = rd;
    if (rd) begin
      exp_data = v;
      exp_chan = 4'(chan_cnt);
      chan_cnt = (chan_cnt + 1) % 16;
    end
    tick();
    exp_valid = 0;
  endtask

  task automatic do_read(input logic [23:0] v);
    tag = "R5";
    rdy = 1'b0;
    cyc(2);
    run_xfer('0, 24, 1, v);
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R8 watchdog: actual hung expected finished");
      summary();
    end
  end

  initial begin
    rst_n = 1'b0;
    rdy   = 1'b1;
    repeat (2) @(negedge clk);
    // R1 reset values
    tag = "R1";
    cyc(2);
    rst_n = 1'b1;
    // R2 setup frame after CS_GAP-1 high cycles; ready toggles inside it are ignored (R6)
    tag = "R2";
    cyc(GAP - 1);
    run_xfer(TABLE, CFGB, 0, '0);
    // R6 no edge: stays idle
    tag = "R6";
    cyc(GAP - 1 + 20);
    do_read(24'hA5C396);
    // R5 earliest edge that still lands in idle
    cyc(GAP - 2);
    do_read(24'h000001);
    // R6 edge detected on the gap's last edge is lost; level alone does nothing
    cyc(GAP - 3);
    tag = "R6";
    rdy = 1'b0;
    cyc(30);
    rdy = 1'b1;
    cyc(3);
    do_read(24'hFFFFFF);
    cyc(GAP);
    do_read(24'h800000);
    cyc(GAP + 1);
    do_read(24'h7FFFFF);
    // R9 wrap of the channel index over many results
    for (int i = 0; i < 16; i++) begin
      tag = "R6";
      cyc(GAP - 1 + (i % 3));
      do_read(24'(i * 32'h10A3B5) ^ 24'h5A5A5A);
    end
    cyc(10);
    done = 1;
    summary();
  end
endmodule